// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer for 9-bit words whose write side and read side run on separate, unrelated clocks. The depth is a power-of-two parameter. Words go in on the write clock and come out, in the order they were written, through a registered output on the read clock. Four active-low status flags report the fill level. Empty and almost-empty belong to the read clock. Full and almost-full belong to the write clock. The two almost thresholds are supplied as input levels, so the surrounding logic can set and change them without any programming sequence.

The write port has two enable inputs and works in one of two modes. The mode is fixed by the level of the second enable while reset is held. In single-enable mode only the first (active-low) enable matters. In two-enable mode the second enable must also be high for a word to be stored, which lets an outer controller share one write stream between several buffers. Reads need both active-low read enables. An output-enable input qualifies the data output: a separate drive-enable output tells the pad or bus logic when the word may be driven.

Pointers cross between the clocks in Gray code through two-flop synchronizers. A flag therefore reaches its active state on the very edge that causes it in its own domain. It returns to inactive a few edges after the other side has moved.

Top module: `twoclk_fifo`

## Requirements
- R1: A word is stored on a rising `wclk` edge exactly when `wr_en_a_n` is 0, `full_n` is 1, and, in two-enable mode, `wr_en_b` is 1. In single-enable mode `wr_en_b` has no effect on writes.
- R2: While `rst` is 1, the write mode is loaded from `wr_en_b` on every `wclk` edge (1 selects two-enable mode, 0 selects single-enable mode). After reset ends, changes on `wr_en_b` never change the mode.
- R3: A read happens on a rising `rclk` edge exactly when `rd_en_a_n` and `rd_en_b_n` are both 0 and `empty_n` is 1. After that edge `rdata` holds the next word, in write order. With only one read enable low, no read happens.
- R4: A write attempted while `full_n` is 0 stores nothing. A read attempted while `empty_n` is 0 removes nothing, and `rdata` keeps the last word that was validly read.
- R5: Counting from the write clock's view, `full_n` is 0 exactly when DEPTH words are held, and it goes to 0 on the edge of the write that filled the buffer. Counting from the read clock's view, `empty_n` is 0 exactly when no word is held, and it goes to 0 on the edge of the read that took the last word.
- R6: `almost_empty_n` is 0 when the read side sees at most `ae_level` unread words, and 1 when it sees `ae_level`+1 or more.
- R7: `almost_full_n` is 0 when the write side sees at least DEPTH − `af_level` unread words, and 1 when more than `af_level` locations are free.
- R8: While `rst` is 1, and on the first edge after it ends: `empty_n` = 0, `almost_empty_n` = 0, `full_n` = 1, `almost_full_n` = 1, and `rdata` = 0.
- R9: `rdata_oe` is 1 exactly when `out_en_n` is 0. The value on `rdata` does not depend on `out_en_n`.
- R10: After one word is written into an empty, idle buffer, `empty_n` rises within 5 `rclk` edges. A read on the next edge then presents that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, seen by both clocks |
| wr_en_a_n | input | 1 | Primary write enable, active low |
| wr_en_b | input | 1 | Second write enable (two-enable mode); mode select while in reset |
| wdata | input | 9 | Write data |
| rd_en_a_n | input | 1 | First read enable, active low |
| rd_en_b_n | input | 1 | Second read enable, active low |
| out_en_n | input | 1 | Output qualifier, active low |
| ae_level | input | log2(DEPTH)+1 | Almost-empty threshold n |
| af_level | input | log2(DEPTH)+1 | Almost-full threshold m |
| rdata | output | 9 | Registered read data |
| rdata_oe | output | 1 | High when rdata may be driven onto a bus |
| empty_n | output | 1 | Empty flag, active low, read clock |
| almost_empty_n | output | 1 | Almost-empty flag, active low, read clock |
| full_n | output | 1 | Full flag, active low, write clock |
| almost_full_n | output | 1 | Almost-full flag, active low, write clock |

## Verification
A pointer that drifts or skips shows up at the ports in one of two ways. Either the word coming out on the read edge is not the next one in write order, or a flag disagrees with the fill level at the edge of a one-sided burst, when the other side is quiet. Both kinds of fault show up on the very access that exposes them. A wrong latched write mode shows as stored or dropped words after the bus has settled. A synchronizer that is too slow or stuck shows as empty or full staying active after the bounded number of edges. Threshold faults are exposed by sweeping both thresholds across the whole fill range, including zero and one below the depth.

// File: rtl/tcf_pkg.sv
package tcf_pkg;

    localparam int WORD_W       = 9;
    localparam int DEF_AE_LEVEL = 7;
    localparam int DEF_AF_LEVEL = 7;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_DUAL   = 1'b1
    } wr_mode_e;

    typedef struct packed {
        logic full_n;
        logic almost_full_n;
    } wr_flags_t;

    typedef struct packed {
        logic empty_n;
        logic almost_empty_n;
    } rd_flags_t;

    // Gray to binary on a zero-extended 32-bit value; callers slice the result.
    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/tcf_sync_ptr.sv
module tcf_sync_ptr
    import tcf_pkg::*;
#(
    parameter int PTR_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PTR_W-1:0] gray_in,
    output logic [PTR_W-1:0] bin_out
);
    logic [PTR_W-1:0] stage1;
    logic [PTR_W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= gray_in;
            stage2 <= stage1;
        end
    end

    logic [31:0] wide_bin;
    always_comb begin
        wide_bin = gray_to_bin(32'(stage2));
        bin_out  = wide_bin[PTR_W-1:0];
    end
endmodule

// File: rtl/tcf_wr_side.sv
module tcf_wr_side
    import tcf_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int PTR_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_a_n,
    input  logic              wr_en_b,
    input  logic [PTR_W-1:0]  rbin_sync,
    input  logic [PTR_W-1:0]  af_level,
    output logic              wr_fire,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [PTR_W-1:0]  wbin,
    output logic [PTR_W-1:0]  wgray,
    output wr_mode_e          mode,
    output wr_flags_t         flags
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [PTR_W:0] CMP_DEPTH = (PTR_W+1)'(DEPTH);

    logic [PTR_W-1:0] wbin_nxt;
    logic [PTR_W-1:0] fill;
    logic             near_top;
    logic             en_ok;

    always_comb begin
        en_ok    = !wr_en_a_n && ((mode == MODE_SINGLE) || wr_en_b);
        wr_fire  = en_ok && flags.full_n;
        wbin_nxt = wbin + {{(PTR_W-1){1'b0}}, wr_fire};
        fill     = wbin_nxt - rbin_sync;
        near_top = ({1'b0, fill} + {1'b0, af_level}) >= CMP_DEPTH;
        wr_addr  = wbin[ADDR_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode  <= wr_mode_e'(wr_en_b);
            wbin  <= '0;
            wgray <= '0;
            flags <= '{full_n: 1'b1, almost_full_n: 1'b1};
        end else begin
            wbin                <= wbin_nxt;
            wgray               <= wbin_nxt ^ (wbin_nxt >> 1);
            flags.full_n        <= (fill != PTR_W'(DEPTH));
            flags.almost_full_n <= !near_top;
        end
    end
endmodule

// File: rtl/tcf_rd_side.sv
module tcf_rd_side
    import tcf_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int PTR_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en_a_n,
    input  logic              rd_en_b_n,
    input  logic [PTR_W-1:0]  wbin_sync,
    input  logic [PTR_W-1:0]  ae_level,
    output logic              rd_fire,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [PTR_W-1:0]  rbin,
    output logic [PTR_W-1:0]  rgray,
    output rd_flags_t         flags
);
    logic [PTR_W-1:0] rbin_nxt;
    logic [PTR_W-1:0] level;

    always_comb begin
        rd_fire  = !rd_en_a_n && !rd_en_b_n && flags.empty_n;
        rbin_nxt = rbin + {{(PTR_W-1){1'b0}}, rd_fire};
        level    = wbin_sync - rbin_nxt;
        rd_addr  = rbin[ADDR_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin  <= '0;
            rgray <= '0;
            flags <= '{empty_n: 1'b0, almost_empty_n: 1'b0};
        end else begin
            rbin                 <= rbin_nxt;
            rgray                <= rbin_nxt ^ (rbin_nxt >> 1);
            flags.empty_n        <= (level != '0);
            flags.almost_empty_n <= (level > ae_level);
        end
    end
endmodule

// File: rtl/twoclk_fifo.sv
module twoclk_fifo
    import tcf_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                       wclk,
    input  logic                       rclk,
    input  logic                       rst,
    input  logic                       wr_en_a_n,
    input  logic                       wr_en_b,
    input  logic [WORD_W-1:0]          wdata,
    input  logic                       rd_en_a_n,
    input  logic                       rd_en_b_n,
    input  logic                       out_en_n,
    input  logic [$clog2(DEPTH):0]     ae_level,
    input  logic [$clog2(DEPTH):0]     af_level,
    output logic [WORD_W-1:0]          rdata,
    output logic                       rdata_oe,
    output logic                       empty_n,
    output logic                       almost_empty_n,
    output logic                       full_n,
    output logic                       almost_full_n
);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int PTR_W  = ADDR_W + 1;

    logic              wr_fire, rd_fire;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [PTR_W-1:0]  wbin, wgray, rbin, rgray;
    logic [PTR_W-1:0]  wbin_at_r, rbin_at_w;
    wr_mode_e          wr_mode;
    wr_flags_t         wflags;
    rd_flags_t         rflags;
    word_t             store [DEPTH];
    word_t             out_q;

    tcf_wr_side #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_wr (
        .clk(wclk), .rst(rst), .wr_en_a_n(wr_en_a_n), .wr_en_b(wr_en_b),
        .rbin_sync(rbin_at_w), .af_level(af_level), .wr_fire(wr_fire),
        .wr_addr(wr_addr), .wbin(wbin), .wgray(wgray), .mode(wr_mode),
        .flags(wflags)
    );

    tcf_rd_side #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_rd (
        .clk(rclk), .rst(rst), .rd_en_a_n(rd_en_a_n), .rd_en_b_n(rd_en_b_n),
        .wbin_sync(wbin_at_r), .ae_level(ae_level), .rd_fire(rd_fire),
        .rd_addr(rd_addr), .rbin(rbin), .rgray(rgray), .flags(rflags)
    );

    tcf_sync_ptr #(.PTR_W(PTR_W)) u_w2r (
        .clk(rclk), .rst(rst), .gray_in(wgray), .bin_out(wbin_at_r)
    );

    tcf_sync_ptr #(.PTR_W(PTR_W)) u_r2w (
        .clk(wclk), .rst(rst), .gray_in(rgray), .bin_out(rbin_at_w)
    );

    always_ff @(posedge wclk) begin
        if (wr_fire) begin
            store[wr_addr] <= wdata;
        end
    end

    always_ff @(posedge rclk) begin
        if (rst) begin
            out_q <= '0;
        end else if (rd_fire) begin
            out_q <= store[rd_addr];
        end
    end

    always_comb begin
        rdata          = out_q;
        rdata_oe       = !out_en_n;
        empty_n        = rflags.empty_n;
        almost_empty_n = rflags.almost_empty_n;
        full_n         = wflags.full_n;
        almost_full_n  = wflags.almost_full_n;
    end
endmodule

// File: rtl/tcf_checker.sv
module tcf_checker #(
    parameter int PTR_W = 7
) (
    input logic             wclk,
    input logic             rclk,
    input logic             rst,
    input logic             wr_en_a_n,
    input logic             wr_en_b,
    input logic             wr_mode,
    input logic [PTR_W-1:0] wbin,
    input logic [PTR_W-1:0] rbin,
    input logic             full_n,
    input logic             almost_full_n,
    input logic             empty_n,
    input logic             almost_empty_n,
    input logic [8:0]       rdata
);
    // R1: an idle primary enable leaves the write pointer alone
    assert_idle_no_write_R1: assert property (@(posedge wclk) disable iff (rst)
        wr_en_a_n |=> $stable(wbin));

    // R1: in two-enable mode a low second enable blocks the write
    assert_dual_gate_R1: assert property (@(posedge wclk) disable iff (rst)
        (wr_mode && !wr_en_b) |=> $stable(wbin));

    assert_mode_frozen_R2: assert property (@(posedge wclk) disable iff (rst)
        $stable(wr_mode));

    assert_no_overflow_R4: assert property (@(posedge wclk) disable iff (rst)
        !full_n |=> $stable(wbin));

    assert_no_underflow_R4: assert property (@(posedge rclk) disable iff (rst)
        !empty_n |=> $stable(rbin));

    assert_hold_on_empty_R4: assert property (@(posedge rclk) disable iff (rst)
        !empty_n |=> $stable(rdata));

    assert_full_implies_near_R7: assert property (@(posedge wclk) disable iff (rst)
        !full_n |-> !almost_full_n);

    assert_empty_implies_near_R6: assert property (@(posedge rclk) disable iff (rst)
        !empty_n |-> !almost_empty_n);

    assert_wr_reset_state_R8: assert property (@(posedge wclk) disable iff (rst)
        $past(rst) |-> (full_n && almost_full_n));

    assert_rd_reset_state_R8: assert property (@(posedge rclk) disable iff (rst)
        $past(rst) |-> (!empty_n && !almost_empty_n && rdata == 9'd0));
endmodule

bind twoclk_fifo tcf_checker #(.PTR_W(PTR_W)) u_chk (
    .wclk(wclk), .rclk(rclk), .rst(rst), .wr_en_a_n(wr_en_a_n),
    .wr_en_b(wr_en_b), .wr_mode(wr_mode), .wbin(wbin), .rbin(rbin),
    .full_n(full_n), .almost_full_n(almost_full_n), .empty_n(empty_n),
    .almost_empty_n(almost_empty_n), .rdata(rdata)
);

// File: tb/sim_twoclk_fifo.sv
`timescale 1ns/100ps
module sim_twoclk_fifo;
    import tcf_pkg::*;

    localparam int DEPTH = 64;
    localparam int LW    = $clog2(DEPTH) + 1;

    logic wclk = 1'b0, rclk = 1'b0, rst = 1'b1;
    logic wr_en_a_n = 1'b1, wr_en_b = 1'b0;
    logic rd_en_a_n = 1'b1, rd_en_b_n = 1'b1, out_en_n = 1'b0;
    logic [8:0] wdata = '0;
    logic [LW-1:0] ae_level = LW'(DEF_AE_LEVEL), af_level = LW'(DEF_AF_LEVEL);
    logic [8:0] rdata;
    logic rdata_oe, empty_n, almost_empty_n, full_n, almost_full_n;

    twoclk_fifo #(.DEPTH(DEPTH)) u0 (
        .wclk(wclk), .rclk(rclk), .rst(rst), .wr_en_a_n(wr_en_a_n),
        .wr_en_b(wr_en_b), .wdata(wdata), .rd_en_a_n(rd_en_a_n),
        .rd_en_b_n(rd_en_b_n), .out_en_n(out_en_n), .ae_level(ae_level),
        .af_level(af_level), .rdata(rdata), .rdata_oe(rdata_oe),
        .empty_n(empty_n), .almost_empty_n(almost_empty_n),
        .full_n(full_n), .almost_full_n(almost_full_n)
    );

    always #10   wclk = ~wclk;   // 50 MHz
    always #13.5 rclk = ~rclk;   // unrelated read clock

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [8:0] model[$];
    logic [8:0] last_word = '0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr_flags_chk(input int cnt, input int m);
        chk("R5", "full_n", int'(full_n), int'(cnt != DEPTH));
        chk("R7", "almost_full_n", int'(almost_full_n), int'(cnt < DEPTH - m));
    endtask

    task automatic rd_flags_chk(input int cnt, input int n);
        chk("R5", "empty_n", int'(empty_n), int'(cnt != 0));
        chk("R6", "almost_empty_n", int'(almost_empty_n), int'(cnt > n));
    endtask

    task automatic idle_all();
        wr_en_a_n = 1'b1;
        rd_en_a_n = 1'b1;
        rd_en_b_n = 1'b1;
    endtask

    task automatic settle();
        idle_all();
        repeat (6) @(negedge rclk);
        repeat (6) @(negedge wclk);
    endtask

    task automatic do_reset(input logic mode_b);
        rst = 1'b1;
        wr_en_b = mode_b;
        idle_all();
        repeat (5) @(negedge wclk);
        repeat (5) @(negedge rclk);
        chk("R8", "empty_n in reset", int'(empty_n), 0);
        chk("R8", "almost_empty_n in reset", int'(almost_empty_n), 0);
        chk("R8", "full_n in reset", int'(full_n), 1);
        chk("R8", "almost_full_n in reset", int'(almost_full_n), 1);
        chk("R8", "rdata in reset", int'(rdata), 0);
        @(negedge wclk);
        rst = 1'b0;
        model.delete();
        last_word = '0;
        repeat (4) @(negedge rclk);
        repeat (4) @(negedge wclk);
    endtask

    // Drives one write-clock cycle starting at a wclk falling edge.
    task automatic wr_step(input logic a_n, input logic b, input logic [8:0] d);
        wr_en_a_n = a_n;
        wr_en_b = b;
        wdata = d;
        @(negedge wclk);
    endtask

    task automatic sweep(input int n, input int m);
        bit acc;
        logic [8:0] d;
        ae_level = LW'(n);
        af_level = LW'(m);
        do_reset(1'b0);
        settle();
        // fill past the top
        for (int k = 0; k < DEPTH + 2; k++) begin
            acc = (model.size() < DEPTH);
            chk("R1", "pre-edge full_n", int'(full_n), int'(acc));
            d = 9'((k * 37 + n * 5 + m) & 9'h1ff);
            wr_step(1'b0, 1'b0, d);
            if (acc) model.push_back(d);
            wr_flags_chk(model.size(), m);
            if ((k % 16) == 15) begin
                settle();
                rd_flags_chk(model.size(), n);
            end
        end
        settle();
        rd_flags_chk(model.size(), n);
        // drain past the bottom
        @(negedge rclk);
        for (int k = 0; k < DEPTH + 2; k++) begin
            acc = (model.size() > 0);
            rd_en_a_n = 1'b0;
            rd_en_b_n = 1'b0;
            @(negedge rclk);
            if (acc) begin
                last_word = model.pop_front();
                chk("R3", "read word", int'(rdata), int'(last_word));
            end else begin
                chk("R4", "rdata held after blocked read", int'(rdata), int'(last_word));
            end
            rd_flags_chk(model.size(), n);
            if ((k % 16) == 15) begin
                settle();
                wr_flags_chk(model.size(), m);
                @(negedge rclk);
            end
        end
        settle();
        wr_flags_chk(0, m);
    endtask

    task automatic read_expect(input string req, input int exp);
        @(negedge rclk);
        rd_en_a_n = 1'b0;
        rd_en_b_n = 1'b0;
        @(negedge rclk);
        idle_all();
        chk(req, "read word", int'(rdata), exp);
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // threshold sweeps, single-enable mode
        sweep(DEF_AE_LEVEL, DEF_AF_LEVEL);
        sweep(0, 0);
        sweep(1, DEPTH - 1);
        sweep(DEPTH - 1, 1);
        sweep(20, 33);

        // two-enable mode
        ae_level = LW'(DEF_AE_LEVEL);
        af_level = LW'(DEF_AF_LEVEL);
        do_reset(1'b1);
        @(negedge wclk);
        for (int i = 0; i < 4; i++) wr_step(1'b0, 1'b0, 9'(i));
        for (int i = 0; i < 2; i++) wr_step(1'b1, 1'b1, 9'(i));
        wr_en_b = 1'b0;
        settle();
        chk("R1", "second enable low blocks write (two-enable)", int'(empty_n), 0);
        chk("R2", "mode held after wr_en_b fell", int'(empty_n), 0);
        @(negedge wclk);
        for (int i = 0; i < 3; i++) begin
            wr_step(1'b0, 1'b1, 9'(9'h1a0 + i));
            model.push_back(9'(9'h1a0 + i));
        end
        settle();
        rd_flags_chk(3, DEF_AE_LEVEL);
        @(negedge rclk);
        rd_en_a_n = 1'b0; rd_en_b_n = 1'b1;
        @(negedge rclk);
        rd_en_a_n = 1'b1; rd_en_b_n = 1'b0;
        @(negedge rclk);
        idle_all();
        chk("R3", "one read enable alone does not read", int'(rdata), 0);
        for (int i = 0; i < 3; i++) begin
            last_word = model.pop_front();
            read_expect("R3", int'(last_word));
        end
        read_expect("R4", int'(last_word));

        // output qualifier
        out_en_n = 1'b1;
        #1;
        chk("R9", "rdata_oe with out_en_n high", int'(rdata_oe), 0);
        chk("R9", "rdata unaffected", int'(rdata), int'(last_word));
        out_en_n = 1'b0;
        #1;
        chk("R9", "rdata_oe with out_en_n low", int'(rdata_oe), 1);

        // single-enable mode ignores the second enable
        do_reset(1'b0);
        @(negedge wclk);
        wr_step(1'b0, 1'b1, 9'h0aa);
        wr_step(1'b0, 1'b0, 9'h055);
        wr_step(1'b1, 1'b1, 9'h111);
        settle();
        read_expect("R1", 9'h0aa);
        read_expect("R2", 9'h055);
        settle();
        chk("R1", "idle primary enable stored nothing", int'(empty_n), 0);

        // first-word latency
        begin
            int edges;
            @(negedge wclk);
            wr_step(1'b0, 1'b0, 9'h155);
            idle_all();
            edges = 0;
            while (!empty_n && edges < 10) begin
                @(negedge rclk);
                edges++;
            end
            chk("R10", "empty_n rose within 5 rclk edges", int'(edges <= 5), 1);
            chk("R10", "rdata before the read", int'(rdata), 9'h055);
            read_expect("R10", 9'h155);
        end

        // reset from a full buffer
        @(negedge wclk);
        for (int i = 0; i < DEPTH; i++) wr_step(1'b0, 1'b0, 9'(i));
        idle_all();
        chk("R5", "full before reset", int'(full_n), 0);
        do_reset(1'b0);
        settle();
        rd_flags_chk(0, DEF_AE_LEVEL);

        // concurrent traffic, scoreboard on order
        fork
            begin
                @(negedge wclk);
                for (int i = 0; i < 300; i++) begin
                    logic a_n;
                    bit acc;
                    a_n = (i % 3 == 2);
                    acc = !a_n && full_n;
                    wr_step(a_n, 1'b0, 9'((i * 11 + 3) & 9'h1ff));
                    if (acc) model.push_back(9'((i * 11 + 3) & 9'h1ff));
                end
                wr_en_a_n = 1'b1;
            end
            begin
                @(negedge rclk);
                for (int i = 0; i < 400; i++) begin
                    bit acc;
                    rd_en_a_n = (i % 4 == 0);
                    rd_en_b_n = 1'b0;
                    acc = !rd_en_a_n && empty_n;
                    @(negedge rclk);
                    if (acc) begin
                        chk("R3", "word available in model", int'(model.size() > 0), 1);
                        if (model.size() > 0) begin
                            last_word = model.pop_front();
                            chk("R3", "concurrent read order", int'(rdata), int'(last_word));
                        end
                    end
                end
                rd_en_a_n = 1'b1;
                rd_en_b_n = 1'b1;
            end
        join
        settle();
        while (model.size() > 0) begin
            last_word = model.pop_front();
            read_expect("R3", int'(last_word));
        end
        settle();
        rd_flags_chk(0, DEF_AE_LEVEL);
        wr_flags_chk(0, DEF_AF_LEVEL);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule